// File: doc/BRIEF.md
# Serialized Interrupt Bus Host Controller

This block is the host end of a one-wire interrupt bus that runs on the bus clock. The wire is open-drain. The host pulls it low through `drive_low` and reads the resolved level on `line_in`. The block walks the bus through repeating cycles:

1. A Start Frame.
2. A programmable run of IRQ/Data frames, each three clocks long. The host samples the wire in the first clock of each frame, and a low level means that interrupt is asserted.
3. A Stop Frame whose low width sets the mode of the next cycle.

After each cycle the block loads the collected interrupt levels onto a parallel vector and pulses a done strobe.

The state machine has six states:

- `ST_GAP` is the released clock that follows every Stop Frame, and also the state after reset.
- `ST_START` is the Start Frame the host begins itself.
- `ST_QWAIT` is quiet-mode idle, where the host watches for a slave pulling the wire low.
- `ST_QSTART` is the host finishing a Start Frame that a slave began.
- `ST_FRAME` is the IRQ/Data frames.
- `ST_STOP` is the Stop Frame.

The transitions are:

- `ST_GAP` goes to `ST_START` in continuous mode and to `ST_QWAIT` in quiet mode.
- `ST_QWAIT` goes to `ST_QSTART` when the wire is sampled low.
- `ST_START` and `ST_QSTART` go to `ST_FRAME` once the Start Frame has been low for eight clocks in total.
- `ST_FRAME` goes to `ST_STOP` at the end of the last frame's turnaround clock.
- `ST_STOP` goes to `ST_GAP` after two clocks (next cycle quiet) or three clocks (next cycle continuous).

Top module: `sirq_host`

## Requirements
- R1: While `rst_n` is low the wire is released, `irq_vec` is zero and `cycle_done` is low. After reset the host is in continuous mode and starts the first cycle on its own in the first clock after reset ends.
- R2: A Start Frame begun by the host holds `drive_low` high for exactly 8 consecutive clocks. The first IRQ/Data frame begins in the clock right after it.
- R3: Each IRQ/Data frame lasts 3 clocks: sample, recovery and turnaround. Bit i of `irq_vec` is 1 exactly when `line_in` was low in the sample clock of frame i, with frame 0 first after the Start Frame.
- R4: A low level on the wire during a recovery or turnaround clock leaves the corresponding `irq_vec` bit at 0.
- R5: The frame count is taken from `frame_count` during the Start Frame. A value of 0 means 1 frame and a value above 32 means 32 frames. The `irq_vec` bits at or above the frame count read 0.
- R6: Right after the last frame the host drives a Stop Frame. It is 2 clocks low when `quiet_sel` was 1 at the end of the last frame, and 3 clocks low when it was 0.
- R7: After a 3-clock Stop Frame the wire stays released for exactly one clock, and the host then starts the next cycle itself.
- R8: After a 2-clock Stop Frame the host never pulls the wire low on its own. When a slave pulls it low for one clock, the host drives it low for the following 7 clocks, making an 8-clock Start Frame.
- R9: `irq_vec` changes only together with a one-clock `cycle_done` pulse. That pulse comes in the first Stop Frame clock of each cycle, and there is exactly one pulse per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all driving and sampling on its rising edge |
| rst_n | input | 1 | Active-low reset |
| line_in | input | 1 | Resolved level of the shared wire |
| drive_low | output | 1 | 1 pulls the shared wire low, 0 releases it |
| quiet_sel | input | 1 | Mode requested for the next cycle: 1 quiet, 0 continuous |
| frame_count | input | 6 | Number of IRQ/Data frames per cycle |
| irq_vec | output | 32 | Interrupt levels of the last completed cycle, bit i = frame i |
| cycle_done | output | 1 | One-clock pulse when `irq_vec` is loaded |

## Verification
The hardest situation to reach is a quiet-mode cycle. The bench has to request quiet mode during the preceding cycle so that the Stop Frame is two clocks wide. It then leaves the wire idle long enough to show that the host does not start by itself, and finally acts as a slave with a single low clock. The scoreboarded cycles chain through continuous, quiet and back to continuous mode. They cover frame counts of 0, 5, 17, 32 and 40 so that both clamps are hit, and one cycle adds low pulses in recovery and turnaround clocks to show they are ignored.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_GAP,
        ST_START,
        ST_QWAIT,
        ST_QSTART,
        ST_FRAME,
        ST_STOP
    } sirq_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOVER,
        PH_TURN
    } sirq_phase_e;

endpackage

// File: rtl/sirq_frame_seq.sv
module sirq_frame_seq
    import sirq_pkg::*;
#(
    parameter int MAX_FRAMES = 32,
    parameter int CW = $clog2(MAX_FRAMES + 1),
    parameter int IW = $clog2(MAX_FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] frames,
    output sirq_phase_e   phase,
    output logic [IW-1:0] idx,
    output logic          last
);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= PH_SAMPLE;
            idx   <= '0;
        end else begin
            unique case (phase)
                PH_SAMPLE:  phase <= PH_RECOVER;
                PH_RECOVER: phase <= PH_TURN;
                PH_TURN: begin
                    phase <= PH_SAMPLE;
                    idx   <= idx + IW'(1);
                end
                default:    phase <= PH_SAMPLE;
            endcase
        end
    end

    assign last = (phase == PH_TURN) && ((CW'(idx) + CW'(1)) == frames);

    // R5: the frame index never passes the programmed count
    p_idx_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (CW'(idx) < frames));

endmodule

// File: rtl/sirq_vec_capture.sv
module sirq_vec_capture #(
    parameter int MAX_FRAMES = 32,
    parameter int IW = $clog2(MAX_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sample_en,
    input  logic [IW-1:0]         idx,
    input  logic                  line_in,
    input  logic                  commit,
    output logic [MAX_FRAMES-1:0] irq_vec,
    output logic                  done
);

    logic [MAX_FRAMES-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            irq_vec  <= '0;
            done     <= 1'b0;
        end else begin
            done <= commit;
            if (commit) begin
                irq_vec  <= shadow_q;
                shadow_q <= '0;
            end else if (sample_en) begin
                shadow_q[idx] <= ~line_in;
            end
        end
    end

    // R9: the done strobe lasts one clock
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the vector only moves on a commit
    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(irq_vec));

endmodule

// File: rtl/sirq_host.sv
module sirq_host
    import sirq_pkg::*;
#(
    parameter int MAX_FRAMES = 32,
    parameter int START_LEN  = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 line_in,
    output logic                                 drive_low,
    input  logic                                 quiet_sel,
    input  logic [$clog2(MAX_FRAMES + 1)-1:0]    frame_count,
    output logic [MAX_FRAMES-1:0]                irq_vec,
    output logic                                 cycle_done
);

    localparam int CW = $clog2(MAX_FRAMES + 1);
    localparam int IW = $clog2(MAX_FRAMES);
    localparam int TW = $clog2(START_LEN);

    sirq_state_e   state_q, state_d;
    logic [TW-1:0] cnt_q;
    logic          quiet_q;
    logic [CW-1:0] frames_q, eff_frames;
    sirq_phase_e   phase;
    logic [IW-1:0] idx;
    logic          last, seq_run, sample_en, commit;

    always_comb begin
        if (frame_count == '0)
            eff_frames = CW'(1);
        else if (frame_count > CW'(MAX_FRAMES))
            eff_frames = CW'(MAX_FRAMES);
        else
            eff_frames = frame_count;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GAP:    state_d = quiet_q ? ST_QWAIT : ST_START;
            ST_START,
            ST_QSTART: if (cnt_q == TW'(START_LEN - 1)) state_d = ST_FRAME;
            ST_QWAIT:  if (!line_in) state_d = ST_QSTART;
            ST_FRAME:  if (last) state_d = ST_STOP;
            ST_STOP:   if (cnt_q == (quiet_q ? TW'(1) : TW'(2))) state_d = ST_GAP;
            default:   state_d = ST_GAP;
        endcase
    end

    // state register and its companions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_GAP;
            cnt_q    <= '0;
            quiet_q  <= 1'b0;
            frames_q <= CW'(MAX_FRAMES);
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= (state_d == ST_QSTART) ? TW'(1) : '0;
            else
                cnt_q <= cnt_q + TW'(1);
            if (state_q == ST_FRAME && last)
                quiet_q <= quiet_sel;
            if (state_q == ST_START || state_q == ST_QSTART)
                frames_q <= eff_frames;
        end
    end

    // outputs
    always_comb begin
        drive_low = (state_q == ST_START) || (state_q == ST_QSTART) || (state_q == ST_STOP);
        seq_run   = (state_q == ST_FRAME);
        sample_en = seq_run && (phase == PH_SAMPLE);
        commit    = seq_run && last;
    end

    sirq_frame_seq #(.MAX_FRAMES(MAX_FRAMES), .CW(CW), .IW(IW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (seq_run),
        .frames (frames_q),
        .phase  (phase),
        .idx    (idx),
        .last   (last)
    );

    sirq_vec_capture #(.MAX_FRAMES(MAX_FRAMES), .IW(IW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .idx       (idx),
        .line_in   (line_in),
        .commit    (commit),
        .irq_vec   (irq_vec),
        .done      (cycle_done)
    );

    // R7: continuous mode restarts right after the released clock
    p_cont_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && !quiet_q) |=> (state_q == ST_START));

    // R8: quiet idle with a high wire stays idle
    p_quiet_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QWAIT && line_in) |=> (state_q == ST_QWAIT));

    // R2: frames begin only after a full-length Start Frame
    p_start_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FRAME && $past(state_q) != ST_FRAME) |-> ($past(cnt_q) == TW'(START_LEN - 1)));

    // R6: the Stop Frame is entered only from the frames
    p_stop_after_frames_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && $past(state_q) != ST_STOP) |-> ($past(state_q) == ST_FRAME));

endmodule

// File: tb/sirq_host_bench.sv
`timescale 1ns/1ps
module sirq_host_bench;

    localparam int NF = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_low = 1'b0;
    logic          quiet_sel = 1'b0;
    logic [5:0]    frame_count = 6'd17;
    logic          drive_low, cycle_done, line_in;
    logic [NF-1:0] irq_vec;

    int nvec = 0;
    int nbad = 0;
    logic [NF-1:0] exp_q[$];
    logic [NF-1:0] prev_vec = '0;
    bit stable_bad = 1'b0;

    always #2.5 clk = ~clk;

    assign line_in = ~(drive_low | slave_low);

    sirq_host u_sirq_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_in     (line_in),
        .drive_low   (drive_low),
        .quiet_sel   (quiet_sel),
        .frame_count (frame_count),
        .irq_vec     (irq_vec),
        .cycle_done  (cycle_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] expv);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: got %0h expected %0h", req, got, expv);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (cycle_done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 32'(irq_vec), 32'd0);
                end else begin
                    logic [NF-1:0] e;
                    e = exp_q.pop_front();
                    chk(irq_vec == e, "R3 R5 vector", 32'(irq_vec), 32'(e));
                end
            end else if (irq_vec != prev_vec) begin
                stable_bad = 1'b1;
            end
            prev_vec = irq_vec;
        end
    end

    // one full bus cycle as seen from the slaves
    task automatic run_cycle(input logic [NF-1:0] vec, input int fc, input bit cur_quiet,
                             input bit next_quiet, input bit noise, input bit first);
        int n;
        int w;
        bit idle_ok;
        logic [NF-1:0] m;
        n = (fc == 0) ? 1 : ((fc > NF) ? NF : fc);
        m = (n == NF) ? '1 : ((NF'(1) << n) - NF'(1));
        exp_q.push_back(vec & m);
        frame_count = 6'(fc);
        quiet_sel = next_quiet;
        if (cur_quiet) begin
            idle_ok = 1'b1;
            repeat (10) begin
                @(negedge clk);
                if (drive_low) idle_ok = 1'b0;
            end
            chk(idle_ok, "R8 quiet idle", 32'(!idle_ok), 32'd0);
            slave_low = 1'b1;
            @(negedge clk);
            slave_low = 1'b0;
            chk(drive_low == 1'b1, "R8 host takes over", 32'(drive_low), 32'd1);
            w = 0;
            while (drive_low) begin w++; @(negedge clk); end
            chk(w == 7, "R8 completion width", 32'(w), 32'd7);
        end else begin
            if (first) begin
                while (!drive_low) @(negedge clk);
            end else begin
                @(negedge clk);
                chk(drive_low == 1'b1, "R7 restart after one clock", 32'(drive_low), 32'd1);
            end
            w = 0;
            while (drive_low) begin w++; @(negedge clk); end
            chk(w == 8, "R2 start width", 32'(w), 32'd8);
        end
        for (int i = 0; i < n; i++) begin
            slave_low = vec[i];
            @(negedge clk);
            slave_low = noise & ~vec[i];   // R4: low outside the sample clock
            @(negedge clk);
            @(negedge clk);
            slave_low = 1'b0;
        end
        chk(drive_low == 1'b1, "R6 stop follows frames", 32'(drive_low), 32'd1);
        w = 0;
        while (drive_low) begin w++; @(negedge clk); end
        chk(w == (next_quiet ? 2 : 3), "R6 stop width", 32'(w), next_quiet ? 32'd2 : 32'd3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(drive_low == 1'b0, "R1 released in reset", 32'(drive_low), 32'd0);
        chk(irq_vec == '0, "R1 vector in reset", 32'(irq_vec), 32'd0);
        chk(cycle_done == 1'b0, "R1 done in reset", 32'(cycle_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(drive_low == 1'b1, "R1 first start on its own", 32'(drive_low), 32'd1);
        run_cycle(32'h0001_A5C3, 17, 1'b0, 1'b0, 1'b0, 1'b1);
        run_cycle(32'hABC0_0016, 5,  1'b0, 1'b0, 1'b1, 1'b0);  // R4 noise, R5 masking
        run_cycle(32'hFFFF_FFFF, 32, 1'b0, 1'b1, 1'b0, 1'b0);
        run_cycle(32'h8000_1234, 40, 1'b1, 1'b1, 1'b0, 1'b0);  // R5 clamp high
        run_cycle(32'hFFFF_FFFF, 0,  1'b1, 1'b0, 1'b0, 1'b0);  // R5 zero means one
        run_cycle(32'h0000_5A5A, 17, 1'b0, 1'b0, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 one done per cycle", 32'(exp_q.size()), 32'd0);
        chk(!stable_bad, "R9 vector moves only with done", 32'(stable_bad), 32'd0);
        finish_run();
    end

endmodule